// File: doc/BRIEF.md
# Random Generator Register Controller

This block is the register front end and control sequencer of a hardware random-number peripheral. A host reaches it through a simple 32-bit register bus (select, write enable, byte address, write data, registered read data) and is notified through a single interrupt line. Through the registers the host identifies the block, starts a seed operation or a self-test, sets interrupt masks and the automatic-reseed enable, reads done and error flags, reads an error code, and pops random words from a small output queue.

Seed and self-test are modelled as timed operations whose lengths are parameters. A successful seed lets the output queue fill from a 32-bit pseudo-random placeholder source. A failed seed blocks the fill and leaves an error code behind. Two clear commands behave differently. One drops only a pending interrupt and only when no error is present. The other wipes the error state together with the interrupt. With automatic reseeding enabled, the block starts a new seed on its own after a fixed number of words has been served. A test input lets a bench force a statistical failure on a seed.

Read data appears on `bus_rdata` in the cycle after the read is presented. Writes take effect at the clock edge where they are presented.

Top module: `rng_regctl`

## Requirements
- R1: Reading byte address 0x00 returns a constant identity word: type code in bits 31:28 (default 2), major revision in bits 15:8 (default 1), minor revision in bits 7:0 (default 3), other bits zero, so 0x2000_0103 by default. After reset, the status (0x0C), error (0x10) and control (0x08) registers read zero and `irq` is low.
- R2: The control register at 0x08 stores bit 4 (auto-reseed enable), bit 5 (done-interrupt mask) and bit 6 (error-interrupt mask). Its other bits read back as zero. The command register at 0x04 always reads zero.
- R3: Writing bit 0 of the command register starts a self-test. Its done flag (status bit 4) is set at the clock edge SELFTEST_CYCLES after the write edge, and not before.
- R4: Writing bit 1 of the command register starts a seed. Its done flag (status bit 5) is set SEED_CYCLES edges after the write. On success the output queue fills, one word per cycle, until its level (status bits 11:8) reaches FIFO_DEPTH.
- R5: If `stat_fail_force` is high at the edge where a seed starts, that seed ends with status bit 5 set, status bit 16 (error) set and error code 0x0000_0008 at address 0x10. No word is then added to the queue. A later seed started with the input low succeeds.
- R6: `irq` is a register that follows ((status bit 4 OR status bit 5) AND NOT mask_done) OR (error AND NOT mask_error), one cycle after those values.
- R7: Command bit 4 (clear interrupt) clears both done flags only when the error flag is zero. With an error present it changes nothing.
- R8: Command bit 5 (clear error) clears the error flag, the error code and both done flags.
- R9: Each word pushed into the queue is the next state of a 32-bit Galois LFSR: shift right, and XOR 0x8020_0003 when the bit shifted out is 1. The LFSR starts at 0x1F2E_3D4C after reset, so the first word is the step of that value. Reading 0x14 pops the oldest word and lowers the level.
- R10: Reading 0x14 while the queue is empty returns zero and leaves the level at zero. The level never exceeds FIFO_DEPTH.
- R11: With auto-reseed enabled, after RESEED_WORDS words have been popped (counted only while enabled), the block starts a seed by itself, which sets status bit 5. With auto-reseed disabled, no pop ever starts a seed.
- R12: A command write with bits 0 and 1 both set starts only the self-test. A start command that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq | output | 1 | Registered interrupt request |
| stat_fail_force | input | 1 | Test input: the seed started while high ends with a statistical failure |

## Verification
The bench targets the done-flag timing to the exact cycle. A sequencer that is off by one shows up as a poll count one too low or too high. It issues clear-interrupt while an error is pending, so a design that ignores the error guard would drop the done flags and the interrupt. It pops the queue in random bursts while the queue refills and compares every word with a bench LFSR model, which exposes lost words, duplicated words and wrong tap masks. It also reads the empty queue, reseeds after a forced failure, masks each interrupt source, and counts served words up to the auto-reseed threshold with the feature both on and off. An underflowing queue, a seed that fills the queue after a failure, or a reseed that triggers without the enable would each break one of these checks.

// File: rtl/rng_regctl_pkg.sv
package rng_regctl_pkg;
  localparam int unsigned OFS_VER  = 'h00;
  localparam int unsigned OFS_CMD  = 'h04;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_ERR  = 'h10;
  localparam int unsigned OFS_FIFO = 'h14;

  localparam int unsigned CMD_SELFTEST = 0;
  localparam int unsigned CMD_SEED     = 1;
  localparam int unsigned CMD_CLR_INT  = 4;
  localparam int unsigned CMD_CLR_ERR  = 5;

  localparam int unsigned CTL_AUTO     = 4;
  localparam int unsigned CTL_MSK_DONE = 5;
  localparam int unsigned CTL_MSK_ERR  = 6;

  localparam logic [31:0] ERR_STAT_FAIL = 32'h0000_0008;

  typedef enum logic [1:0] {OP_IDLE, OP_SELFTEST, OP_SEED} op_kind_e;
endpackage

// File: rtl/rng_op_seq.sv
module rng_op_seq
  import rng_regctl_pkg::*;
#(
  parameter int unsigned SEED_CYCLES     = 40,
  parameter int unsigned SELFTEST_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start_st,
  input  logic start_seed,
  input  logic fail_in,
  output logic busy,
  output logic fin_st,
  output logic fin_seed,
  output logic fin_fail
);
  localparam int unsigned MAXC  = (SEED_CYCLES > SELFTEST_CYCLES) ? SEED_CYCLES : SELFTEST_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  op_kind_e           kind;
  logic [CNT_W-1:0]   cnt;
  logic               fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      kind   <= OP_IDLE;
      cnt    <= '0;
      fail_q <= 1'b0;
    end else if (!busy) begin
      if (start_st) begin
        busy   <= 1'b1;
        kind   <= OP_SELFTEST;
        cnt    <= CNT_W'(SELFTEST_CYCLES - 1);
        fail_q <= 1'b0;
      end else if (start_seed) begin
        busy   <= 1'b1;
        kind   <= OP_SEED;
        cnt    <= CNT_W'(SEED_CYCLES - 1);
        fail_q <= fail_in;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
      kind <= OP_IDLE;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign fin_st   = busy && (cnt == '0) && (kind == OP_SELFTEST);
  assign fin_seed = busy && (cnt == '0) && (kind == OP_SEED);
  assign fin_fail = fin_seed && fail_q;
endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [W-1:0] INIT    = 32'h1F2E_3D4C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] nxt
);
  logic [W-1:0] state;

  assign nxt = state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);

  always_ff @(posedge clk) begin
    if (rst)      state <= INIT;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/rng_out_fifo.sv
module rng_out_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign head  = mem[rp];
  assign empty = (level == '0);
  assign full  = (level == ($clog2(DEPTH+1))'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/rng_regctl.sv
module rng_regctl
  import rng_regctl_pkg::*;
#(
  parameter int unsigned ADDR_W          = 6,
  parameter int unsigned FIFO_DEPTH      = 8,
  parameter int unsigned SEED_CYCLES     = 40,
  parameter int unsigned SELFTEST_CYCLES = 24,
  parameter int unsigned RESEED_WORDS    = 12,
  parameter logic [3:0]  TYPE_CODE       = 4'd2,
  parameter logic [7:0]  REV_MAJOR       = 8'd1,
  parameter logic [7:0]  REV_MINOR       = 8'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              stat_fail_force
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned SRV_W = $clog2(RESEED_WORDS + 1);

  logic ctl_auto, msk_done, msk_err;
  logic st_done, seed_done, err_flag, seeded;
  logic [31:0] err_code;
  logic [SRV_W-1:0] served;

  logic wr_cmd, wr_ctrl, rd_fifo;
  logic start_st, start_seed, auto_trig;
  logic op_busy, op_fin_st, op_fin_seed, op_fail;
  logic q_push, q_pop, q_empty, q_full;
  logic [31:0] q_head, lfsr_nxt;
  logic [LVL_W-1:0] q_level;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  assign wr_cmd  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_ctrl = bus_sel && bus_wr  && (bus_addr == ADDR_W'(OFS_CTRL));
  assign rd_fifo = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_FIFO));

  assign auto_trig  = ctl_auto && (served >= SRV_W'(RESEED_WORDS)) && !op_busy;
  assign start_st   = wr_cmd && bus_wdata[CMD_SELFTEST];
  assign start_seed = (wr_cmd && bus_wdata[CMD_SEED]) || auto_trig;

  rng_op_seq #(.SEED_CYCLES(SEED_CYCLES), .SELFTEST_CYCLES(SELFTEST_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start_st(start_st), .start_seed(start_seed),
    .fail_in(stat_fail_force), .busy(op_busy), .fin_st(op_fin_st),
    .fin_seed(op_fin_seed), .fin_fail(op_fail)
  );

  assign q_push = seeded && !op_busy && !q_full && !err_flag;
  assign q_pop  = rd_fifo && !q_empty;

  rng_lfsr #(.W(32)) u_lfsr (
    .clk(clk), .rst(rst), .adv(q_push), .nxt(lfsr_nxt)
  );

  rng_out_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .wdata(lfsr_nxt), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(q_full), .level(q_level)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_auto <= 1'b0;
      msk_done <= 1'b0;
      msk_err  <= 1'b0;
    end else if (wr_ctrl) begin
      ctl_auto <= bus_wdata[CTL_AUTO];
      msk_done <= bus_wdata[CTL_MSK_DONE];
      msk_err  <= bus_wdata[CTL_MSK_ERR];
    end
  end

  // served-word counter for automatic reseeding
  always_ff @(posedge clk) begin
    if (rst || !ctl_auto)                    served <= '0;
    else if (auto_trig)                      served <= q_pop ? SRV_W'(1) : '0;
    else if (q_pop && served < SRV_W'(RESEED_WORDS)) served <= served + 1'b1;
  end

  // flags: clear commands first, operation completion wins
  always_ff @(posedge clk) begin
    if (rst) begin
      st_done   <= 1'b0;
      seed_done <= 1'b0;
      err_flag  <= 1'b0;
      err_code  <= '0;
      seeded    <= 1'b0;
    end else begin
      if (wr_cmd && bus_wdata[CMD_CLR_ERR]) begin
        err_flag  <= 1'b0;
        err_code  <= '0;
        st_done   <= 1'b0;
        seed_done <= 1'b0;
      end else if (wr_cmd && bus_wdata[CMD_CLR_INT] && !err_flag) begin
        st_done   <= 1'b0;
        seed_done <= 1'b0;
      end
      if (op_fin_st) st_done <= 1'b1;
      if (op_fin_seed) begin
        seed_done <= 1'b1;
        if (op_fail) begin
          err_flag <= 1'b1;
          err_code <= ERR_STAT_FAIL;
          seeded   <= 1'b0;
        end else begin
          seeded   <= 1'b1;
        end
      end
    end
  end

  // registered read data and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ((st_done || seed_done) && !msk_done) || (err_flag && !msk_err);
      bus_rdata <= '0;
      if (bus_sel && !bus_wr) begin
        unique case (bus_addr)
          ADDR_W'(OFS_VER):  bus_rdata <= {TYPE_CODE, 12'h000, REV_MAJOR, REV_MINOR};
          ADDR_W'(OFS_CTRL): bus_rdata <= {25'd0, msk_err, msk_done, ctl_auto, 4'd0};
          ADDR_W'(OFS_STAT): bus_rdata <= {15'd0, err_flag, 4'd0, 4'(q_level), 2'd0,
                                           seed_done, st_done, 4'd0};
          ADDR_W'(OFS_ERR):  bus_rdata <= err_code;
          ADDR_W'(OFS_FIFO): bus_rdata <= q_empty ? 32'd0 : q_head;
          default:           bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rng_regctl_chk.sv
module rng_regctl_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              st_done,
  input logic              seed_done,
  input logic              err_flag,
  input logic [31:0]       err_code,
  input logic              msk_done,
  input logic              msk_err,
  input logic [LVL_W-1:0]  q_level,
  input logic              op_fin_st,
  input logic              op_fin_seed,
  input logic              op_fail
);
  logic rd_cmd_c, rd_fifo_c, wcmd_c, fin_c;
  assign rd_cmd_c  = bus_sel && !bus_wr && (bus_addr == ADDR_W'('h04));
  assign rd_fifo_c = bus_sel && !bus_wr && (bus_addr == ADDR_W'('h14));
  assign wcmd_c    = bus_sel && bus_wr  && (bus_addr == ADDR_W'('h04));
  assign fin_c     = op_fin_st || op_fin_seed;

  a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_cmd_c |=> (bus_rdata == 32'd0));

  a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_fifo_c && q_level == '0) |=> (bus_rdata == 32'd0));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    q_level <= LVL_W'(DEPTH));

  a_r5_stat_code: assert property (@(posedge clk) disable iff (rst)
    (op_fin_seed && op_fail) |=> (err_flag && err_code == 32'h8));

  a_r7_clr_int_err_kept: assert property (@(posedge clk) disable iff (rst)
    (wcmd_c && bus_wdata[4] && !bus_wdata[5] && err_flag && (st_done || seed_done))
      |=> (err_flag && (st_done || seed_done)));

  a_r8_clr_err_all: assert property (@(posedge clk) disable iff (rst)
    (wcmd_c && bus_wdata[5] && !fin_c)
      |=> (!err_flag && err_code == 32'd0 && !st_done && !seed_done));

  a_r6_both_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (msk_done && msk_err) |=> !irq);

  a_r3_done_needs_op: assert property (@(posedge clk) disable iff (rst)
    $rose(st_done) |-> $past(op_fin_st));
endmodule

bind rng_regctl rng_regctl_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .st_done(st_done),
  .seed_done(seed_done), .err_flag(err_flag), .err_code(err_code),
  .msk_done(msk_done), .msk_err(msk_err), .q_level(q_level),
  .op_fin_st(op_fin_st), .op_fin_seed(op_fin_seed), .op_fail(op_fail)
);

// File: tb/rng_regctl_tb.sv
module rng_regctl_tb;
  localparam int AW     = 6;
  localparam int DEPTH  = 8;
  localparam int SEEDC  = 40;
  localparam int STC    = 24;
  localparam int RESEED = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0, stat_fail_force = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_lfsr = 32'h1F2E_3D4C;

  always #4 clk = ~clk;

  rng_regctl #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH), .SEED_CYCLES(SEEDC),
               .SELFTEST_CYCLES(STC), .RESEED_WORDS(RESEED)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .stat_fail_force(stat_fail_force)
  );

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  function automatic logic [31:0] stat_word(input bit err, input int lvl, input bit sd, input bit td);
    return {15'd0, err, 4'd0, 4'(lvl), 2'd0, sd, td, 4'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(posedge clk); #2;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic poll(input int bitpos, input int limit, output int n);
    logic [31:0] d;
    n = 0;
    do begin
      rd('h0C, d);
      n++;
    end while (!d[bitpos] && n < limit);
  endtask

  task automatic pop_check(input string req);
    logic [31:0] d;
    rd('h14, d);
    exp_lfsr = lfsr_step(exp_lfsr);
    check(req, d, exp_lfsr);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240));
    idle(3);
    rst = 1'b0;
    #0;
    // R1 reset state and identity
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd('h00, d); check("R1 version", d, 32'h2000_0103);
    rd('h0C, d); check("R1 status", d, 32'd0);
    rd('h10, d); check("R1 error", d, 32'd0);
    rd('h08, d); check("R1 control", d, 32'd0);

    // R2 control readback, random values, command reads zero
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = $urandom;
      wr('h08, v);
      rd('h08, d); check("R2 ctrl", d, v & 32'h70);
    end
    wr('h08, 32'd0);
    rd('h04, d); check("R2 cmd", d, 32'd0);

    // R10 empty read
    rd('h14, d); check("R10 empty data", d, 32'd0);
    rd('h0C, d); check("R10 empty level", d, 32'd0);

    // R3 self-test timing, R6 irq, R7 clear without error
    wr('h04, 32'h1);
    poll(4, 200, n); check("R3 selftest cycles", n, STC + 1);
    check("R6 irq done", {31'd0, irq}, 32'd1);
    wr('h04, 32'h10); idle(1);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);
    rd('h0C, d); check("R7 done cleared", d, 32'd0);

    // R6 done mask
    wr('h08, 32'h20);
    wr('h04, 32'h1);
    poll(4, 200, n); idle(1);
    check("R6 masked done irq", {31'd0, irq}, 32'd0);
    wr('h08, 32'h0); idle(1);
    check("R6 unmasked irq", {31'd0, irq}, 32'd1);
    wr('h04, 32'h10);

    // R5 forced statistical failure
    stat_fail_force = 1'b1;
    wr('h04, 32'h2);
    stat_fail_force = 1'b0;
    poll(5, 200, n); check("R5 seed cycles", n, SEEDC + 1);
    rd('h0C, d); check("R5 status", d, stat_word(1, 0, 1, 0));
    rd('h10, d); check("R5 code", d, 32'h8);
    check("R6 irq err", {31'd0, irq}, 32'd1);
    wr('h08, 32'h20); idle(1);
    check("R6 err only irq", {31'd0, irq}, 32'd1);
    wr('h08, 32'h60); idle(1);
    check("R6 all masked", {31'd0, irq}, 32'd0);
    wr('h08, 32'h0);
    // R7 clear-int ignored while error present
    wr('h04, 32'h10); idle(2);
    rd('h0C, d); check("R7 kept with error", d, stat_word(1, 0, 1, 0));
    check("R7 irq kept", {31'd0, irq}, 32'd1);
    // R8 clear error
    wr('h04, 32'h20); idle(1);
    rd('h0C, d); check("R8 status", d, 32'd0);
    rd('h10, d); check("R8 code", d, 32'd0);
    check("R8 irq", {31'd0, irq}, 32'd0);
    idle(10);
    rd('h0C, d); check("R5 no fill", d, 32'd0);

    // R4 successful seed and fill
    wr('h04, 32'h2);
    rd('h0C, d); check("R4 not early", d, 32'd0);
    poll(5, 200, n); check("R4 seed cycles", n, SEEDC);
    idle(DEPTH + 2);
    rd('h0C, d); check("R4 full", d, stat_word(0, DEPTH, 1, 0));
    wr('h04, 32'h10);

    // R9 random burst pops
    for (int b = 0; b < 6; b++) begin
      int len;
      len = 1 + int'($urandom % DEPTH);
      for (int k = 0; k < len; k++) pop_check("R9 word");
      idle(DEPTH + 2);
      rd('h0C, d); check("R9 refill level", d, stat_word(0, DEPTH, 0, 0));
    end

    // R11 auto disabled: no reseed
    for (int k = 0; k < RESEED + 2; k++) pop_check("R11 word off");
    idle(SEEDC + 5);
    rd('h0C, d); check("R11 no reseed when off", d[5], 1'b0);

    // R11 auto enabled
    wr('h08, 32'h10);
    for (int k = 0; k < RESEED / 2; k++) pop_check("R11 word on");
    idle(DEPTH + 2);
    for (int k = 0; k < RESEED - RESEED / 2; k++) pop_check("R11 word on");
    rd('h0C, d); check("R11 not yet", d[5], 1'b0);
    idle(SEEDC + 4);
    rd('h0C, d); check("R11 auto reseed", d[5], 1'b1);
    wr('h08, 32'h0);
    wr('h04, 32'h10);
    idle(DEPTH + 2);
    pop_check("R9 after reseed");

    // R12 both start bits
    wr('h04, 32'h3);
    wr('h04, 32'h2);
    poll(4, 200, n); check("R12 selftest wins", n, STC);
    rd('h0C, d); check("R12 no seed", d[5], 1'b0);
    idle(SEEDC + 4);
    rd('h0C, d); check("R12 busy start ignored", d[5], 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule